// File: doc/BRIEF.md
# Function-to-Pin Routing Selector Matrix

This block connects a set of on-chip peripheral function signals to a bank of package pins. Each function owns a 7-bit selector that names the pin it drives. Each selector sits in a 32-bit configuration word together with one other selector. Every selector bit has its own write-enable bit in the same word, so a single write can update one field, or only some bits of a field, and leave the rest untouched.

Each function presents an output level and an output enable. The matrix forwards them to the selected pin and returns that pin's input level to the function. A pin joins the routing only while its ownership input marks it as function-routed. A pin held by the general-purpose I/O logic is neither driven nor sampled by any function. The ownership registers and the GPIO bank sit outside this block and reach it only through that ownership input. The selectors are the only state. All routing is combinational from them, so a new setting takes effect right after the clock edge that writes it.

Top module: `pinroute_matrix`

## Requirements
- R1: After reset every selector is 0. Every configuration word reads 0 and no pin has its output enable set.
- R2: Word w holds function 2w and function 2w+1. The even function's selector is at bits 6:0 with its write-enable bits at 22:16. The odd function's selector is at bits 14:8 with its write-enable bits at 30:24.
- R3: A write changes a selector bit only when the matching write-enable bit is 1 in the same data word. Selector bits whose write-enable bit is 0 keep their value.
- R4: A read of word w returns the two selectors at bits 6:0 and 14:8, with all other bits 0. A word index at or above the number of words reads 0, and a write to such an index changes nothing.
- R5: A selector value v from 1 to 64 routes the function to pin v+7, so pins 8 to 71 can be reached. Value 0, and any value whose pin would lie beyond the last pin, leaves the function unrouted.
- R6: When a pin is selected by a function and its ownership input is 0, the pin's output and output enable follow that function's output and output enable.
- R7: While a pin's ownership input is 1, its output and output enable are 0, and any function that selects it sees an input of 0.
- R8: When several functions select the same pin, the lowest-numbered one drives it. Every one of them receives the pin's input level.
- R9: An unrouted function sees an input of 0. A pin that no function selects has output and output enable 0.
- R10: A selector change shows on the pins in the cycle after the write edge. Writing 0 releases the old pin, and writing another value moves the function off its old pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | IDXW | Word index of the write |
| cfg_wr_data | input | 32 | Write data: selectors and their write-enable bits |
| cfg_rd_idx | input | IDXW | Word index of the read |
| cfg_rd_data | output | 32 | Read data: selectors, other bits 0 |
| fn_out | input | NF | Output level of each function |
| fn_oe | input | NF | Output enable of each function |
| fn_in | output | NF | Input level returned to each function |
| pin_in | input | NP | Level seen on each pin |
| pin_gpio_own | input | NP | 1 = pin held by GPIO logic, 0 = function-routed |
| pin_out | output | NP | Output level driven to each pin |
| pin_oe | output | NP | Output enable driven to each pin |

## Verification
The bench goes after partial write-enable patterns inside one field. A design that gated whole fields instead of single bits would change the masked-off bits. It drives selector 64 (the last reachable pin) and 65 (one beyond it). An off-by-one in the decoder would either lose pin 71 or wrap onto a pin that does not exist. It puts two functions on one pin with opposite levels, where wrong priority shows as the higher function's level on the pin. It also claims a routed pin for GPIO, which catches a design that gates the output but still passes the pin level back to the function. Writes to word indices past the last word check that an incomplete address decode does not alias them onto real selectors.

// File: rtl/pinroute_pkg.sv
// Shared constants for the pin routing matrix: selector width, the
// offset between selector code and pin number, and the word layout.
package pinroute_pkg;
    localparam int SEL_W      = 7;   // bits per selector field
    localparam int PIN_OFS    = 7;   // code v selects pin v + PIN_OFS
    localparam int HALF_SHIFT = 8;   // odd function sits this far above the even one
    localparam int MASK_SHIFT = 16;  // write-enable bits sit this far above their field
    localparam int WORD_W     = 32;  // configuration word width
endpackage

// File: rtl/pinroute_sel_regs.sv
// Selector register file. Holds one SEL_W-bit selector per function,
// two functions per configuration word, with a write-enable bit per
// selector bit. Assumes one write per cycle; reads are combinational.
module pinroute_sel_regs
    import pinroute_pkg::*;
#(
    parameter int NF   = 8,
    parameter int IDXW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDXW-1:0]       wr_idx,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic [IDXW-1:0]       rd_idx,
    output logic [WORD_W-1:0]     rd_data,
    output logic [NF*SEL_W-1:0]   sel_flat
);
    logic [SEL_W-1:0] sel_q [NF];

    for (genvar f = 0; f < NF; f++) begin : g_fn
        localparam int W  = f / 2;
        localparam int SH = (f % 2) * HALF_SHIFT;
        localparam logic [IDXW-1:0] WIDX = W[IDXW-1:0];

        // Update each selector bit whose write-enable bit is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[f] <= '0;
            end else if (wr_en && wr_idx == WIDX) begin
                for (int b = 0; b < SEL_W; b++) begin
                    if (wr_data[MASK_SHIFT + SH + b]) sel_q[f][b] <= wr_data[SH + b];
                end
            end
        end

        assign sel_flat[f*SEL_W +: SEL_W] = sel_q[f];
    end

    // Assemble the read word: selector fields only, everything else zero.
    always_comb begin
        rd_data = '0;
        for (int f = 0; f < NF; f++) begin
            if (rd_idx == IDXW'(f / 2)) rd_data[(f % 2) * HALF_SHIFT +: SEL_W] = sel_q[f];
        end
    end
endmodule

// File: rtl/pinroute_decode.sv
// Selector decoder. Turns each function's selector into a one-hot row of
// pin hits, gated by pin ownership, and returns each function's input
// level. Assumes pins at or below PIN_OFS cannot be selected.
module pinroute_decode
    import pinroute_pkg::*;
#(
    parameter int NF = 8,
    parameter int NP = 72
) (
    input  logic [NF*SEL_W-1:0] sel_flat,
    input  logic [NP-1:0]       pin_in,
    input  logic [NP-1:0]       pin_gpio_own,
    output logic [NF*NP-1:0]    hit_flat,
    output logic [NF-1:0]       fn_in
);
    for (genvar f = 0; f < NF; f++) begin : g_fn
        logic [SEL_W-1:0] sel;
        logic [NP-1:0]    match;
        assign sel = sel_flat[f*SEL_W +: SEL_W];

        for (genvar p = 0; p < NP; p++) begin : g_pin
            if (p > PIN_OFS && p - PIN_OFS < 2**SEL_W) begin : g_reach
                localparam int CODE_I = p - PIN_OFS;
                localparam logic [SEL_W-1:0] CODE = CODE_I[SEL_W-1:0];
                assign match[p] = (sel == CODE);
            end else begin : g_unreach
                assign match[p] = 1'b0;
            end
        end

        // A hit needs a matching selector and a function-routed pin.
        assign hit_flat[f*NP +: NP] = match & ~pin_gpio_own;
        // Return the level of the hit pin; zero when there is none.
        assign fn_in[f] = |(hit_flat[f*NP +: NP] & pin_in);
    end
endmodule

// File: rtl/pinroute_arbiter.sv
// Per-pin driver selection. Among the functions that hit a pin, the
// lowest-numbered one supplies its output level and enable. Pins with
// no hit are driven low with the enable off.
module pinroute_arbiter #(
    parameter int NF = 8,
    parameter int NP = 72
) (
    input  logic [NF*NP-1:0] hit_flat,
    input  logic [NF-1:0]    fn_out,
    input  logic [NF-1:0]    fn_oe,
    output logic [NP-1:0]    pin_out,
    output logic [NP-1:0]    pin_oe
);
    for (genvar p = 0; p < NP; p++) begin : g_pin
        // Scan from the top so the lowest hitting function is assigned last.
        always_comb begin
            pin_out[p] = 1'b0;
            pin_oe[p]  = 1'b0;
            for (int f = NF - 1; f >= 0; f--) begin
                if (hit_flat[f*NP + p]) begin
                    pin_out[p] = fn_out[f];
                    pin_oe[p]  = fn_oe[f];
                end
            end
        end
    end
endmodule

// File: rtl/pinroute_matrix.sv
// Top of the function-to-pin routing matrix. Joins the selector register
// file, the decoder and the per-pin arbiter. Assumes NF functions fit in
// 2**IDXW words and that ownership comes from registers outside.
module pinroute_matrix
    import pinroute_pkg::*;
#(
    parameter int NF   = 8,
    parameter int NP   = 72,
    parameter int IDXW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [IDXW-1:0]    cfg_wr_idx,
    input  logic [WORD_W-1:0]  cfg_wr_data,
    input  logic [IDXW-1:0]    cfg_rd_idx,
    output logic [WORD_W-1:0]  cfg_rd_data,
    input  logic [NF-1:0]      fn_out,
    input  logic [NF-1:0]      fn_oe,
    output logic [NF-1:0]      fn_in,
    input  logic [NP-1:0]      pin_in,
    input  logic [NP-1:0]      pin_gpio_own,
    output logic [NP-1:0]      pin_out,
    output logic [NP-1:0]      pin_oe
);
    logic [NF*SEL_W-1:0] sel_flat;
    logic [NF*NP-1:0]    hit_flat;

    pinroute_sel_regs #(.NF(NF), .IDXW(IDXW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_idx   (cfg_wr_idx),
        .wr_data  (cfg_wr_data),
        .rd_idx   (cfg_rd_idx),
        .rd_data  (cfg_rd_data),
        .sel_flat (sel_flat)
    );

    pinroute_decode #(.NF(NF), .NP(NP)) u_dec (
        .sel_flat     (sel_flat),
        .pin_in       (pin_in),
        .pin_gpio_own (pin_gpio_own),
        .hit_flat     (hit_flat),
        .fn_in        (fn_in)
    );

    pinroute_arbiter #(.NF(NF), .NP(NP)) u_arb (
        .hit_flat (hit_flat),
        .fn_out   (fn_out),
        .fn_oe    (fn_oe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );
endmodule

// File: rtl/pinroute_chk.sv
// Property checker for the routing matrix, bound to the top module.
// Observes the configuration port, the held selectors and the pin side.
module pinroute_chk
    import pinroute_pkg::*;
#(
    parameter int NF   = 8,
    parameter int NP   = 72,
    parameter int IDXW = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr_en,
    input logic [IDXW-1:0]    cfg_wr_idx,
    input logic [WORD_W-1:0]  cfg_wr_data,
    input logic [NF*SEL_W-1:0] sel_flat,
    input logic [NF-1:0]      fn_in,
    input logic [NP-1:0]      pin_out,
    input logic [NP-1:0]      pin_oe,
    input logic [NP-1:0]      pin_gpio_own
);
    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (sel_flat == '0));

    // R7
    own_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe | pin_out) & pin_gpio_own) == '0);

    // R3
    no_enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr_en || (cfg_wr_data[31:16] & 16'h7F7F) == 16'h0) |=> $stable(sel_flat));

    for (genvar f = 0; f < NF; f++) begin : g_fn
        localparam int W  = f / 2;
        localparam int SH = (f % 2) * HALF_SHIFT;
        localparam logic [IDXW-1:0] WIDX = W[IDXW-1:0];

        // R9
        unrouted_in_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_flat[f*SEL_W +: SEL_W] == '0) |-> !fn_in[f]);

        // R2
        full_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr_en && cfg_wr_idx == WIDX && cfg_wr_data[MASK_SHIFT + SH +: SEL_W] == '1)
            |=> sel_flat[f*SEL_W +: SEL_W] == $past(cfg_wr_data[SH +: SEL_W]));
    end
endmodule

bind pinroute_matrix pinroute_chk #(.NF(NF), .NP(NP), .IDXW(IDXW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_idx   (cfg_wr_idx),
    .cfg_wr_data  (cfg_wr_data),
    .sel_flat     (sel_flat),
    .fn_in        (fn_in),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .pin_gpio_own (pin_gpio_own)
);

// File: tb/tb_pinroute_matrix.sv
// Self-checking bench: directed corners, then seeded random traffic,
// all compared against a behavioural model kept in the bench.
module tb_pinroute_matrix;
    localparam int NF   = 8;
    localparam int NP   = 72;
    localparam int IDXW = 4;
    localparam int NW   = (NF + 1) / 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_wr_en = 1'b0;
    logic [IDXW-1:0] cfg_wr_idx = '0;
    logic [31:0]     cfg_wr_data = '0;
    logic [IDXW-1:0] cfg_rd_idx = '0;
    logic [31:0]     cfg_rd_data;
    logic [NF-1:0]   fn_out = '0;
    logic [NF-1:0]   fn_oe = '0;
    logic [NF-1:0]   fn_in;
    logic [NP-1:0]   pin_in = '0;
    logic [NP-1:0]   pin_gpio_own = '0;
    logic [NP-1:0]   pin_out;
    logic [NP-1:0]   pin_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [6:0] m_sel [NF];

    always #10 clk = ~clk;

    pinroute_matrix #(.NF(NF), .NP(NP), .IDXW(IDXW)) dut (.*);

    function automatic int exp_pin(int f);
        int v = int'(m_sel[f]);
        if (v >= 1 && v + 7 < NP) return v + 7;
        return -1;
    endfunction

    function automatic logic [31:0] exp_word(int idx);
        logic [31:0] r = '0;
        for (int f = 0; f < NF; f++)
            if (f / 2 == idx) r[(f % 2) * 8 +: 7] = m_sel[f];
        return r;
    endfunction

    function automatic logic [NP-1:0] exp_pin_vec(bit want_oe);
        logic [NP-1:0] r = '0;
        for (int p = 0; p < NP; p++) begin
            for (int f = NF - 1; f >= 0; f--)
                if (exp_pin(f) == p && !pin_gpio_own[p]) r[p] = want_oe ? fn_oe[f] : fn_out[f];
        end
        return r;
    endfunction

    function automatic logic [NF-1:0] exp_fn_in();
        logic [NF-1:0] r = '0;
        for (int f = 0; f < NF; f++) begin
            int p = exp_pin(f);
            if (p >= 0) r[f] = pin_in[p] & ~pin_gpio_own[p];
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write one word, update the model by the per-bit enable rule.
    task automatic cfg_write(int idx, logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_idx = IDXW'(idx);
        cfg_wr_data = data;
        @(posedge clk);
        if (idx < NW)
            for (int f = 0; f < NF; f++)
                if (f / 2 == idx)
                    for (int b = 0; b < 7; b++)
                        if (data[16 + (f % 2) * 8 + b]) m_sel[f][b] = data[(f % 2) * 8 + b];
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Compare all outputs and every readable word against the model.
    task automatic check_all(string tag);
        #1;
        chk({tag, " R6 pin_oe"},  128'(pin_oe),  128'(exp_pin_vec(1'b1)));
        chk({tag, " R8 pin_out"}, 128'(pin_out), 128'(exp_pin_vec(1'b0)));
        chk({tag, " R9 fn_in"},   128'(fn_in),   128'(exp_fn_in()));
        for (int i = 0; i <= NW + 1; i++) begin
            cfg_rd_idx = IDXW'(i);
            #1;
            chk({tag, " R4 readback"}, 128'(cfg_rd_data), 128'(exp_word(i)));
        end
    endtask

    function automatic logic [31:0] word(logic [6:0] ev, logic [6:0] od, logic [6:0] me, logic [6:0] mo);
        return {1'b0, mo, 1'b0, me, 1'b0, od, 1'b0, ev};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int f = 0; f < NF; f++) m_sel[f] = '0;
        fn_out = '1; fn_oe = '1; pin_in = '1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state, no pin enabled, all words zero
        check_all("R1 reset");
        chk("R1 no oe", 128'(pin_oe), 128'(0));

        // R2, R5: f0 -> pin 8, f1 -> pin 71 (code 64)
        cfg_write(0, word(7'd1, 7'd64, 7'h7F, 7'h7F));
        check_all("R2 R5 low/high");
        chk("R5 pin8 oe", 128'(pin_oe[8]), 128'(1));
        chk("R5 pin71 oe", 128'(pin_oe[71]), 128'(1));

        // R3: enable only bit 0 of f0, data 0 -> f0 becomes 0, f1 untouched
        cfg_write(0, word(7'd0, 7'd0, 7'h01, 7'h00));
        check_all("R3 partial");
        chk("R10 pin8 released", 128'(pin_oe[8]), 128'(0));
        chk("R3 f1 kept", 128'(pin_oe[71]), 128'(1));

        // R5: code 65 lies past the last pin -> unrouted
        cfg_write(1, word(7'd65, 7'd0, 7'h7F, 7'h7F));
        check_all("R5 code65");
        chk("R5 code65 fn_in", 128'(fn_in[2]), 128'(0));

        // R8: f2 and f3 both on pin 12, opposite levels
        fn_out = 8'b0000_0100; fn_oe = '1;
        cfg_write(1, word(7'd5, 7'd5, 7'h7F, 7'h7F));
        check_all("R8 collide");
        chk("R8 lower wins", 128'(pin_out[12]), 128'(1));
        chk("R8 both see input", 128'(fn_in[3:2]), 128'(2'b11));

        // R7: GPIO takes pin 12
        pin_gpio_own[12] = 1'b1;
        check_all("R7 own");
        chk("R7 gated oe", 128'(pin_oe[12]), 128'(0));
        chk("R7 gated in", 128'(fn_in[3:2]), 128'(0));
        pin_gpio_own[12] = 1'b0;

        // R4: out-of-range word writes change nothing
        cfg_write(NW + 1, 32'h7F7F_2525);
        check_all("R4 oob write");

        // R10: move f3 from pin 12 to pin 20
        cfg_write(1, word(7'd0, 7'd13, 7'h00, 7'h7F));
        check_all("R10 move");
        chk("R10 new pin", 128'(pin_oe[20]), 128'(1));

        for (int it = 0; it < 400; it++) begin
            logic [6:0] ev = 7'($urandom_range(0, 70));
            logic [6:0] od = 7'($urandom_range(0, 70));
            logic [6:0] me = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h7F;
            logic [6:0] mo = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h7F;
            fn_out = NF'($urandom); fn_oe = NF'($urandom);
            pin_in = {$urandom, $urandom, $urandom};
            pin_gpio_own = ($urandom_range(0, 1) == 0) ? '0 : {$urandom, $urandom, $urandom};
            cfg_write($urandom_range(0, NW), word(ev, od, me, mo));
            check_all("random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule